// File: doc/BRIEF.md
# Two-Master AXI Arbiter With ID Tagging

This block merges two AXI4 masters onto a single AXI4 slave port that feeds one memory-controller channel. Master 0 is the host memory path and carries 8-bit IDs. Master 1 is the accelerator memory path and carries 4-bit IDs. The read-address and write-address channels each have their own round-robin arbiter. A master that requests alone is granted in the same cycle. Once a grant is offered, it stays until the slave accepts the address.

Outgoing IDs are rewritten so that bit 7 names the master that issued the transaction. Response routing therefore needs no state: each read-data or write-response beat goes to the master that bit 7 selects, with its original ID restored. Write data follows the order of write-address grants. A small FIFO of master indices records that order. Data beats are taken from the master at the head of the FIFO until the beat marked last, and then the entry is removed.

Top module: `two_master_axi_arb`

## Requirements
- R1: A master that raises an address valid (read or write) while the other master's valid is low is presented on the slave port in the same cycle. Its address and length pass through unchanged, and the slave's ready is returned only to that master.
- R2: When both masters request on one address channel, the master that did not win that channel's most recent completed handshake is granted. At most one master sees ready on a given address channel in any cycle.
- R3: While the slave-side address valid is high and ready is low, the grant does not change, even if the other master starts requesting and would win a new round.
- R4: Master 0 IDs leave as {0, id[6:0]}. Master 1 IDs leave as {1, 000, id[3:0]}. This applies on both address channels.
- R5: Write-data beats are forwarded only from the master at the head of the order of write-address grants. The slave-side write valid stays low when no granted write burst is outstanding. The beat with last set retires the head entry.
- R6: When WR_FIFO_DEPTH write bursts (default 4) have been granted and have not yet completed their last beat, the slave-side write-address valid is held low and neither master receives write-address ready.
- R7: A read-data beat with ID bit 7 = 1 is delivered to master 1 with ID bits 3:0. A beat with bit 7 = 0 is delivered to master 0 with bit 7 cleared. Data, response and last pass through unchanged.
- R8: Write responses are routed and their IDs restored by the same bit-7 rule as in R7.
- R9: The slave-side response ready equals the ready of the addressed master. The other master's ready has no effect.
- R10: During reset no slave-side valid is driven, provided the masters are idle. The first tie after reset is won by master 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| m0_awvalid | input | 1 | Host write-address valid |
| m0_awready | output | 1 | Host write-address ready |
| m0_awaddr | input | 52 | Host write address |
| m0_awid | input | 8 | Host write ID |
| m0_awlen | input | 8 | Host burst length |
| m0_wvalid | input | 1 | Host write-data valid |
| m0_wready | output | 1 | Host write-data ready |
| m0_wdata | input | 512 | Host write data |
| m0_wstrb | input | 64 | Host byte strobes |
| m0_wlast | input | 1 | Host last beat |
| m0_bvalid | output | 1 | Host write-response valid |
| m0_bready | input | 1 | Host write-response ready |
| m0_bid | output | 8 | Host write-response ID |
| m0_bresp | output | 2 | Host write-response code |
| m0_arvalid | input | 1 | Host read-address valid |
| m0_arready | output | 1 | Host read-address ready |
| m0_araddr | input | 52 | Host read address |
| m0_arid | input | 8 | Host read ID |
| m0_arlen | input | 8 | Host read length |
| m0_rvalid | output | 1 | Host read-data valid |
| m0_rready | input | 1 | Host read-data ready |
| m0_rdata | output | 512 | Host read data |
| m0_rid | output | 8 | Host read ID |
| m0_rresp | output | 2 | Host read response |
| m0_rlast | output | 1 | Host read last |
| m1_awvalid | input | 1 | Accelerator write-address valid |
| m1_awready | output | 1 | Accelerator write-address ready |
| m1_awaddr | input | 52 | Accelerator write address |
| m1_awid | input | 4 | Accelerator write ID |
| m1_awlen | input | 8 | Accelerator burst length |
| m1_wvalid | input | 1 | Accelerator write-data valid |
| m1_wready | output | 1 | Accelerator write-data ready |
| m1_wdata | input | 512 | Accelerator write data |
| m1_wstrb | input | 64 | Accelerator byte strobes |
| m1_wlast | input | 1 | Accelerator last beat |
| m1_bvalid | output | 1 | Accelerator write-response valid |
| m1_bready | input | 1 | Accelerator write-response ready |
| m1_bid | output | 4 | Accelerator write-response ID |
| m1_bresp | output | 2 | Accelerator write-response code |
| m1_arvalid | input | 1 | Accelerator read-address valid |
| m1_arready | output | 1 | Accelerator read-address ready |
| m1_araddr | input | 52 | Accelerator read address |
| m1_arid | input | 4 | Accelerator read ID |
| m1_arlen | input | 8 | Accelerator read length |
| m1_rvalid | output | 1 | Accelerator read-data valid |
| m1_rready | input | 1 | Accelerator read-data ready |
| m1_rdata | output | 512 | Accelerator read data |
| m1_rid | output | 4 | Accelerator read ID |
| m1_rresp | output | 2 | Accelerator read response |
| m1_rlast | output | 1 | Accelerator read last |
| s_awvalid | output | 1 | Merged write-address valid |
| s_awready | input | 1 | Merged write-address ready |
| s_awaddr | output | 52 | Merged write address |
| s_awid | output | 8 | Tagged write ID |
| s_awlen | output | 8 | Merged burst length |
| s_wvalid | output | 1 | Merged write-data valid |
| s_wready | input | 1 | Merged write-data ready |
| s_wdata | output | 512 | Merged write data |
| s_wstrb | output | 64 | Merged byte strobes |
| s_wlast | output | 1 | Merged last beat |
| s_bvalid | input | 1 | Merged write-response valid |
| s_bready | output | 1 | Merged write-response ready |
| s_bid | input | 8 | Tagged write-response ID |
| s_bresp | input | 2 | Write-response code |
| s_arvalid | output | 1 | Merged read-address valid |
| s_arready | input | 1 | Merged read-address ready |
| s_araddr | output | 52 | Merged read address |
| s_arid | output | 8 | Tagged read ID |
| s_arlen | output | 8 | Merged read length |
| s_rvalid | input | 1 | Merged read-data valid |
| s_rready | output | 1 | Merged read-data ready |
| s_rdata | input | 512 | Read data |
| s_rid | input | 8 | Tagged read ID |
| s_rresp | input | 2 | Read response |
| s_rlast | input | 1 | Read last |

## Verification
Address muxing, ID tagging, data steering and response routing are all combinational. Their results are due in the same cycle as the stimulus, so the bench drives at the falling edge and samples one time step later. Arbitration history, grant locking and the write-order FIFO change only at a rising edge, so their effect is checked in the cycle after the handshake that caused it. Each scenario is laid out cycle by cycle: a tie sequence, a stalled grant, ordered write bursts, FIFO saturation, and full 256-value ID sweeps on both response channels.

// File: rtl/axi_arb_pkg.sv
package axi_arb_pkg;
    localparam int DATA_W   = 512;
    localparam int ADDR_W   = 52;
    localparam int ID_W     = 8;
    localparam int ACC_ID_W = 4;
    localparam int LEN_W    = 8;
    localparam int STRB_W   = DATA_W / 8;

    typedef enum logic {SRC_HOST = 1'b0, SRC_ACC = 1'b1} src_t;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [ID_W-1:0]   id;
        logic [LEN_W-1:0]  len;
    } addr_req_t;

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic [STRB_W-1:0] strb;
        logic              last;
    } wbeat_t;

    function automatic logic [ID_W-1:0] tag_host(input logic [ID_W-1:0] id);
        return {1'b0, id[ID_W-2:0]};
    endfunction

    function automatic logic [ID_W-1:0] tag_acc(input logic [ACC_ID_W-1:0] id);
        return {1'b1, {(ID_W-1-ACC_ID_W){1'b0}}, id};
    endfunction

    function automatic src_t src_of(input logic [ID_W-1:0] id);
        return src_t'(id[ID_W-1]);
    endfunction
endpackage

// File: rtl/axi_rr_grant.sv
module axi_rr_grant
    import axi_arb_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] req,
    input  logic       enable,
    input  logic       out_ready,
    output src_t       gnt,
    output logic       out_valid,
    output logic [1:0] ack
);
    src_t last_q;
    src_t lock_idx_q;
    logic lock_q;

    always_comb begin
        if (lock_q)
            gnt = lock_idx_q;
        else if (req == 2'b11)
            gnt = src_t'(~last_q);
        else if (req[1])
            gnt = SRC_ACC;
        else
            gnt = SRC_HOST;
    end

    assign out_valid = req[gnt] & enable;

    for (genvar i = 0; i < 2; i++) begin : g_ack
        assign ack[i] = out_valid & out_ready & (gnt == src_t'(i));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            last_q     <= SRC_ACC;
            lock_q     <= 1'b0;
            lock_idx_q <= SRC_HOST;
        end else if (out_valid && out_ready) begin
            last_q <= gnt;
            lock_q <= 1'b0;
        end else if (out_valid) begin
            lock_q     <= 1'b1;
            lock_idx_q <= gnt;
        end
    end
endmodule

// File: rtl/axi_wsel_fifo.sv
module axi_wsel_fifo
    import axi_arb_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic push,
    input  src_t push_src,
    input  logic pop,
    output src_t head,
    output logic empty,
    output logic full
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    src_t             slot_q [DEPTH];
    logic [PTR_W-1:0] wr_q, rd_q;
    logic [CNT_W-1:0] cnt_q;

    assign empty = (cnt_q == '0);
    assign full  = (cnt_q == CNT_W'(DEPTH));
    assign head  = slot_q[rd_q];

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_q  <= '0;
            rd_q  <= '0;
            cnt_q <= '0;
            for (int i = 0; i < DEPTH; i++) slot_q[i] <= SRC_HOST;
        end else begin
            if (push && !full) begin
                slot_q[wr_q] <= push_src;
                wr_q <= (wr_q == PTR_W'(DEPTH - 1)) ? '0 : wr_q + 1'b1;
            end
            if (pop && !empty)
                rd_q <= (rd_q == PTR_W'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
            case ({push && !full, pop && !empty})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end
endmodule

// File: rtl/axi_resp_steer.sv
module axi_resp_steer
    import axi_arb_pkg::*;
(
    input  logic       s_valid,
    input  src_t       s_dst,
    output logic       s_ready,
    output logic [1:0] m_valid,
    input  logic [1:0] m_ready
);
    for (genvar i = 0; i < 2; i++) begin : g_out
        assign m_valid[i] = s_valid & (s_dst == src_t'(i));
    end
    assign s_ready = m_ready[s_dst];
endmodule

// File: rtl/two_master_axi_arb.sv
module two_master_axi_arb
    import axi_arb_pkg::*;
#(
    parameter int WR_FIFO_DEPTH = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                m0_awvalid,
    output logic                m0_awready,
    input  logic [ADDR_W-1:0]   m0_awaddr,
    input  logic [ID_W-1:0]     m0_awid,
    input  logic [LEN_W-1:0]    m0_awlen,
    input  logic                m0_wvalid,
    output logic                m0_wready,
    input  logic [DATA_W-1:0]   m0_wdata,
    input  logic [STRB_W-1:0]   m0_wstrb,
    input  logic                m0_wlast,
    output logic                m0_bvalid,
    input  logic                m0_bready,
    output logic [ID_W-1:0]     m0_bid,
    output logic [1:0]          m0_bresp,
    input  logic                m0_arvalid,
    output logic                m0_arready,
    input  logic [ADDR_W-1:0]   m0_araddr,
    input  logic [ID_W-1:0]     m0_arid,
    input  logic [LEN_W-1:0]    m0_arlen,
    output logic                m0_rvalid,
    input  logic                m0_rready,
    output logic [DATA_W-1:0]   m0_rdata,
    output logic [ID_W-1:0]     m0_rid,
    output logic [1:0]          m0_rresp,
    output logic                m0_rlast,
    input  logic                m1_awvalid,
    output logic                m1_awready,
    input  logic [ADDR_W-1:0]   m1_awaddr,
    input  logic [ACC_ID_W-1:0] m1_awid,
    input  logic [LEN_W-1:0]    m1_awlen,
    input  logic                m1_wvalid,
    output logic                m1_wready,
    input  logic [DATA_W-1:0]   m1_wdata,
    input  logic [STRB_W-1:0]   m1_wstrb,
    input  logic                m1_wlast,
    output logic                m1_bvalid,
    input  logic                m1_bready,
    output logic [ACC_ID_W-1:0] m1_bid,
    output logic [1:0]          m1_bresp,
    input  logic                m1_arvalid,
    output logic                m1_arready,
    input  logic [ADDR_W-1:0]   m1_araddr,
    input  logic [ACC_ID_W-1:0] m1_arid,
    input  logic [LEN_W-1:0]    m1_arlen,
    output logic                m1_rvalid,
    input  logic                m1_rready,
    output logic [DATA_W-1:0]   m1_rdata,
    output logic [ACC_ID_W-1:0] m1_rid,
    output logic [1:0]          m1_rresp,
    output logic                m1_rlast,
    output logic                s_awvalid,
    input  logic                s_awready,
    output logic [ADDR_W-1:0]   s_awaddr,
    output logic [ID_W-1:0]     s_awid,
    output logic [LEN_W-1:0]    s_awlen,
    output logic                s_wvalid,
    input  logic                s_wready,
    output logic [DATA_W-1:0]   s_wdata,
    output logic [STRB_W-1:0]   s_wstrb,
    output logic                s_wlast,
    input  logic                s_bvalid,
    output logic                s_bready,
    input  logic [ID_W-1:0]     s_bid,
    input  logic [1:0]          s_bresp,
    output logic                s_arvalid,
    input  logic                s_arready,
    output logic [ADDR_W-1:0]   s_araddr,
    output logic [ID_W-1:0]     s_arid,
    output logic [LEN_W-1:0]    s_arlen,
    input  logic                s_rvalid,
    output logic                s_rready,
    input  logic [DATA_W-1:0]   s_rdata,
    input  logic [ID_W-1:0]     s_rid,
    input  logic [1:0]          s_rresp,
    input  logic                s_rlast
);
    addr_req_t aw_req [2];
    addr_req_t ar_req [2];
    wbeat_t    w_beat [2];
    addr_req_t aw_out, ar_out;
    wbeat_t    w_out;
    src_t      aw_gnt, ar_gnt, w_head;
    logic [1:0] aw_ack, ar_ack, r_valid, b_valid;
    logic      w_empty, w_full, w_fwd;

    // Address payloads with tagged IDs
    assign aw_req[0] = '{addr: m0_awaddr, id: tag_host(m0_awid), len: m0_awlen};
    assign aw_req[1] = '{addr: m1_awaddr, id: tag_acc(m1_awid),  len: m1_awlen};
    assign ar_req[0] = '{addr: m0_araddr, id: tag_host(m0_arid), len: m0_arlen};
    assign ar_req[1] = '{addr: m1_araddr, id: tag_acc(m1_arid),  len: m1_arlen};
    assign w_beat[0] = '{data: m0_wdata, strb: m0_wstrb, last: m0_wlast};
    assign w_beat[1] = '{data: m1_wdata, strb: m1_wstrb, last: m1_wlast};

    // Write-address channel, blocked while the order FIFO is full
    axi_rr_grant u_aw_arb (
        .clk(clk), .rst(rst),
        .req({m1_awvalid, m0_awvalid}),
        .enable(!w_full),
        .out_ready(s_awready),
        .gnt(aw_gnt), .out_valid(s_awvalid), .ack(aw_ack)
    );
    assign aw_out     = aw_req[aw_gnt];
    assign s_awaddr   = aw_out.addr;
    assign s_awid     = aw_out.id;
    assign s_awlen    = aw_out.len;
    assign m0_awready = aw_ack[0];
    assign m1_awready = aw_ack[1];

    // Read-address channel
    axi_rr_grant u_ar_arb (
        .clk(clk), .rst(rst),
        .req({m1_arvalid, m0_arvalid}),
        .enable(1'b1),
        .out_ready(s_arready),
        .gnt(ar_gnt), .out_valid(s_arvalid), .ack(ar_ack)
    );
    assign ar_out     = ar_req[ar_gnt];
    assign s_araddr   = ar_out.addr;
    assign s_arid     = ar_out.id;
    assign s_arlen    = ar_out.len;
    assign m0_arready = ar_ack[0];
    assign m1_arready = ar_ack[1];

    // Write-data steering in write-address grant order
    axi_wsel_fifo #(.DEPTH(WR_FIFO_DEPTH)) u_wsel (
        .clk(clk), .rst(rst),
        .push(s_awvalid && s_awready),
        .push_src(aw_gnt),
        .pop(s_wvalid && s_wready && s_wlast),
        .head(w_head), .empty(w_empty), .full(w_full)
    );
    assign w_fwd     = !w_empty;
    assign w_out     = w_beat[w_head];
    assign s_wvalid  = w_fwd && ((w_head == SRC_ACC) ? m1_wvalid : m0_wvalid);
    assign s_wdata   = w_out.data;
    assign s_wstrb   = w_out.strb;
    assign s_wlast   = w_out.last;
    assign m0_wready = w_fwd && (w_head == SRC_HOST) && s_wready;
    assign m1_wready = w_fwd && (w_head == SRC_ACC)  && s_wready;

    // Read-data return
    axi_resp_steer u_r_steer (
        .s_valid(s_rvalid), .s_dst(src_of(s_rid)), .s_ready(s_rready),
        .m_valid(r_valid), .m_ready({m1_rready, m0_rready})
    );
    assign m0_rvalid = r_valid[0];
    assign m1_rvalid = r_valid[1];
    assign m0_rid    = {1'b0, s_rid[ID_W-2:0]};
    assign m1_rid    = s_rid[ACC_ID_W-1:0];
    assign m0_rdata  = s_rdata;
    assign m1_rdata  = s_rdata;
    assign m0_rresp  = s_rresp;
    assign m1_rresp  = s_rresp;
    assign m0_rlast  = s_rlast;
    assign m1_rlast  = s_rlast;

    // Write-response return
    axi_resp_steer u_b_steer (
        .s_valid(s_bvalid), .s_dst(src_of(s_bid)), .s_ready(s_bready),
        .m_valid(b_valid), .m_ready({m1_bready, m0_bready})
    );
    assign m0_bvalid = b_valid[0];
    assign m1_bvalid = b_valid[1];
    assign m0_bid    = {1'b0, s_bid[ID_W-2:0]};
    assign m1_bid    = s_bid[ACC_ID_W-1:0];
    assign m0_bresp  = s_bresp;
    assign m1_bresp  = s_bresp;
endmodule

// File: rtl/two_master_axi_arb_chk.sv
module two_master_axi_arb_chk #(
    parameter int DEPTH = 4
) (
    input logic       clk,
    input logic       rst,
    input logic       m0_arready,
    input logic       m1_arready,
    input logic       m0_awready,
    input logic       m1_awready,
    input logic       s_arvalid,
    input logic       s_arready,
    input logic [7:0] s_arid,
    input logic       s_awvalid,
    input logic       s_awready,
    input logic [7:0] s_awid,
    input logic       s_wvalid,
    input logic       s_wready,
    input logic       s_wlast,
    input logic       m0_rvalid,
    input logic       m1_rvalid,
    input logic [7:0] s_rid,
    input logic       m0_bvalid,
    input logic       m1_bvalid,
    input logic [7:0] s_bid
);
    logic [7:0] open_q;

    always_ff @(posedge clk) begin
        if (rst)
            open_q <= '0;
        else
            open_q <= open_q + 8'(s_awvalid && s_awready)
                             - 8'(s_wvalid && s_wready && s_wlast);
    end

    AST_AR_ONE_READY: assert property (@(posedge clk) disable iff (rst)
        !(m0_arready && m1_arready)); // R2
    AST_AW_ONE_READY: assert property (@(posedge clk) disable iff (rst)
        !(m0_awready && m1_awready)); // R2
    AST_AR_GRANT_HELD: assert property (@(posedge clk) disable iff (rst)
        s_arvalid && !s_arready |=> s_arvalid && $stable(s_arid)); // R3
    AST_AR_ID_TAG: assert property (@(posedge clk) disable iff (rst)
        s_arvalid && s_arid[7] |-> s_arid[6:4] == 3'b000); // R4
    AST_AW_ID_TAG: assert property (@(posedge clk) disable iff (rst)
        s_awvalid && s_awid[7] |-> s_awid[6:4] == 3'b000); // R4
    AST_W_HAS_OWNER: assert property (@(posedge clk) disable iff (rst)
        s_wvalid |-> open_q != 8'd0); // R5
    AST_AW_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        open_q >= 8'(DEPTH) |-> !s_awvalid); // R6
    AST_R_ROUTE: assert property (@(posedge clk) disable iff (rst)
        (m1_rvalid |-> s_rid[7]) and (m0_rvalid |-> !s_rid[7])); // R7
    AST_B_ROUTE: assert property (@(posedge clk) disable iff (rst)
        (m1_bvalid |-> s_bid[7]) and (m0_bvalid |-> !s_bid[7])); // R8
endmodule

bind two_master_axi_arb two_master_axi_arb_chk #(.DEPTH(WR_FIFO_DEPTH)) u_chk (
    .clk(clk), .rst(rst),
    .m0_arready(m0_arready), .m1_arready(m1_arready),
    .m0_awready(m0_awready), .m1_awready(m1_awready),
    .s_arvalid(s_arvalid), .s_arready(s_arready), .s_arid(s_arid),
    .s_awvalid(s_awvalid), .s_awready(s_awready), .s_awid(s_awid),
    .s_wvalid(s_wvalid), .s_wready(s_wready), .s_wlast(s_wlast),
    .m0_rvalid(m0_rvalid), .m1_rvalid(m1_rvalid), .s_rid(s_rid),
    .m0_bvalid(m0_bvalid), .m1_bvalid(m1_bvalid), .s_bid(s_bid)
);

// File: tb/two_master_axi_arb_test.sv
module two_master_axi_arb_test;
    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk;

    logic m0_awvalid, m0_awready; logic [51:0] m0_awaddr; logic [7:0] m0_awid; logic [7:0] m0_awlen;
    logic m0_wvalid, m0_wready; logic [511:0] m0_wdata; logic [63:0] m0_wstrb; logic m0_wlast;
    logic m0_bvalid, m0_bready; logic [7:0] m0_bid; logic [1:0] m0_bresp;
    logic m0_arvalid, m0_arready; logic [51:0] m0_araddr; logic [7:0] m0_arid; logic [7:0] m0_arlen;
    logic m0_rvalid, m0_rready; logic [511:0] m0_rdata; logic [7:0] m0_rid; logic [1:0] m0_rresp; logic m0_rlast;
    logic m1_awvalid, m1_awready; logic [51:0] m1_awaddr; logic [3:0] m1_awid; logic [7:0] m1_awlen;
    logic m1_wvalid, m1_wready; logic [511:0] m1_wdata; logic [63:0] m1_wstrb; logic m1_wlast;
    logic m1_bvalid, m1_bready; logic [3:0] m1_bid; logic [1:0] m1_bresp;
    logic m1_arvalid, m1_arready; logic [51:0] m1_araddr; logic [3:0] m1_arid; logic [7:0] m1_arlen;
    logic m1_rvalid, m1_rready; logic [511:0] m1_rdata; logic [3:0] m1_rid; logic [1:0] m1_rresp; logic m1_rlast;
    logic s_awvalid, s_awready; logic [51:0] s_awaddr; logic [7:0] s_awid; logic [7:0] s_awlen;
    logic s_wvalid, s_wready; logic [511:0] s_wdata; logic [63:0] s_wstrb; logic s_wlast;
    logic s_bvalid, s_bready; logic [7:0] s_bid; logic [1:0] s_bresp;
    logic s_arvalid, s_arready; logic [51:0] s_araddr; logic [7:0] s_arid; logic [7:0] s_arlen;
    logic s_rvalid, s_rready; logic [511:0] s_rdata; logic [7:0] s_rid; logic [1:0] s_rresp; logic s_rlast;

    two_master_axi_arb uut (.*);

    int n_chk = 0;
    int n_bad = 0;

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle_all();
        m0_awvalid = 0; m0_awaddr = '0; m0_awid = '0; m0_awlen = '0;
        m0_wvalid = 0; m0_wdata = '0; m0_wstrb = '0; m0_wlast = 0; m0_bready = 0;
        m0_arvalid = 0; m0_araddr = '0; m0_arid = '0; m0_arlen = '0; m0_rready = 0;
        m1_awvalid = 0; m1_awaddr = '0; m1_awid = '0; m1_awlen = '0;
        m1_wvalid = 0; m1_wdata = '0; m1_wstrb = '0; m1_wlast = 0; m1_bready = 0;
        m1_arvalid = 0; m1_araddr = '0; m1_arid = '0; m1_arlen = '0; m1_rready = 0;
        s_awready = 0; s_wready = 0; s_bvalid = 0; s_bid = '0; s_bresp = '0;
        s_arready = 0; s_rvalid = 0; s_rdata = '0; s_rid = '0; s_rresp = '0; s_rlast = 0;
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=1 expected=0");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        idle_all();
        repeat (2) @(posedge clk);
        #1;
        // R10: nothing valid on the slave side during reset
        check(!s_awvalid && !s_wvalid && !s_arvalid, "R10 reset", {s_awvalid, s_wvalid, s_arvalid}, 0);
        step(); rst = 1'b0;

        // R2/R10: tie on read-address, host wins first then alternation
        for (int k = 0; k < 4; k++) begin
            step();
            m0_arvalid = 1; m0_arid = 8'h11; m1_arvalid = 1; m1_arid = 4'h2; s_arready = 1;
            #1;
            check(m0_arready == (k % 2 == 0), "R2 R10 tie winner", m0_arready, (k % 2 == 0));
            check(m1_arready == (k % 2 == 1), "R2 tie loser", m1_arready, (k % 2 == 1));
        end
        // last winner is master 1 now
        // R3: master 1 stalled alone, then master 0 joins; grant must stay
        step(); idle_all(); m1_arvalid = 1; m1_arid = 4'h6; s_arready = 0;
        #1; check(s_arvalid && s_arid == 8'h86, "R3 stall start", s_arid, 8'h86);
        step(); m0_arvalid = 1; m0_arid = 8'h05;
        #1; check(s_arid == 8'h86 && !m0_arready, "R3 grant held", s_arid, 8'h86);
        step(); s_arready = 1;
        #1; check(m1_arready && !m0_arready && s_arid == 8'h86, "R3 held until ready", {m1_arready, m0_arready}, 2'b10);
        step(); m1_arid = 4'h7;
        #1; check(m0_arready && s_arid == 8'h05, "R2 after held grant", s_arid, 8'h05);
        step(); idle_all();

        // R1/R4: host read ID sweep
        for (int i = 0; i < 256; i++) begin
            step();
            m0_arvalid = 1; m0_arid = 8'(i); m0_araddr = 52'(i * 64); m0_arlen = 8'(i); s_arready = 1;
            #1;
            check(s_arvalid && s_arid == {1'b0, 7'(i)}, "R4 host id tag", s_arid, {1'b0, 7'(i)});
            check(s_araddr == 52'(i * 64) && s_arlen == 8'(i) && m0_arready && !m1_arready, "R1 host pass",
                  s_araddr, 52'(i * 64));
        end
        step(); idle_all();
        // R1/R4: accelerator read ID sweep
        for (int i = 0; i < 16; i++) begin
            step();
            m1_arvalid = 1; m1_arid = 4'(i); m1_araddr = 52'(i + 3); s_arready = 1;
            #1;
            check(s_arid == {4'b1000, 4'(i)}, "R4 acc id tag", s_arid, {4'b1000, 4'(i)});
            check(s_araddr == 52'(i + 3) && m1_arready && !m0_arready, "R1 acc pass", s_araddr, 52'(i + 3));
        end
        step(); idle_all();

        // R5/R4: two write addresses, host granted first on the tie
        step(); m0_awvalid = 1; m0_awid = 8'hF3; m1_awvalid = 1; m1_awid = 4'hA; s_awready = 1;
        #1; check(m0_awready && s_awid == 8'h73, "R4 aw host tag", s_awid, 8'h73);
        step(); m0_awvalid = 0;
        #1; check(m1_awready && s_awid == 8'h8A, "R4 aw acc tag", s_awid, 8'h8A);
        step(); idle_all(); s_wready = 1;
        m0_wvalid = 1; m0_wdata = 512'd1; m0_wlast = 0; m1_wvalid = 1; m1_wdata = 512'd2; m1_wlast = 1;
        #1; check(s_wvalid && s_wdata == 512'd1 && m0_wready && !m1_wready, "R5 head host", s_wdata[63:0], 1);
        step(); m0_wdata = 512'd3; m0_wlast = 1;
        #1; check(s_wdata == 512'd3 && s_wlast && m0_wready, "R5 host last", s_wdata[63:0], 3);
        step(); m0_wvalid = 0;
        #1; check(s_wvalid && s_wdata == 512'd2 && m1_wready && !m0_wready, "R5 head acc", s_wdata[63:0], 2);
        step(); m0_wvalid = 1;
        #1; check(!s_wvalid && !m0_wready && !m1_wready, "R5 empty blocks", s_wvalid, 0);
        step(); idle_all();

        // R6: fill the order FIFO then block
        for (int k = 0; k < 4; k++) begin
            step(); m0_awvalid = 1; m0_awid = 8'(k); s_awready = 1;
            #1; check(s_awvalid && m0_awready, "R6 accept below depth", s_awvalid, 1);
        end
        step();
        #1; check(!s_awvalid && !m0_awready, "R6 full blocks", {s_awvalid, m0_awready}, 0);
        step(); m0_awvalid = 0; s_wready = 1;
        for (int k = 0; k < 4; k++) begin
            m0_wvalid = 1; m0_wlast = 1; m0_wdata = 512'(k + 10);
            #1; check(s_wvalid && s_wdata == 512'(k + 10), "R5 R6 drain", s_wdata[63:0], k + 10);
            step();
        end
        #1; check(!s_wvalid, "R5 drained", s_wvalid, 0);
        step(); idle_all();

        // R7/R9: read-data routing sweep
        for (int i = 0; i < 256; i++) begin
            logic [7:0] iv;
            iv = 8'(i);
            step();
            s_rvalid = 1; s_rid = iv; s_rdata = 512'(i + 7); s_rresp = iv[1:0]; s_rlast = iv[2];
            m0_rready = iv[0]; m1_rready = ~iv[0];
            #1;
            check(m1_rvalid == iv[7] && m0_rvalid == !iv[7], "R7 route", {m1_rvalid, m0_rvalid}, {iv[7], !iv[7]});
            if (iv[7])
                check(m1_rid == iv[3:0] && m1_rdata == 512'(i + 7) && m1_rresp == iv[1:0] && m1_rlast == iv[2],
                      "R7 acc id", m1_rid, iv[3:0]);
            else
                check(m0_rid == iv && m0_rdata == 512'(i + 7) && m0_rlast == iv[2], "R7 host id", m0_rid, iv);
            check(s_rready == (iv[7] ? ~iv[0] : iv[0]), "R9 r ready", s_rready, iv[7] ? ~iv[0] : iv[0]);
        end
        step(); idle_all();

        // R8/R9: write-response routing sweep
        for (int i = 0; i < 256; i++) begin
            logic [7:0] iv;
            iv = 8'(i);
            step();
            s_bvalid = 1; s_bid = iv; s_bresp = iv[5:4];
            m0_bready = ~iv[1]; m1_bready = iv[1];
            #1;
            check(m1_bvalid == iv[7] && m0_bvalid == !iv[7], "R8 route", {m1_bvalid, m0_bvalid}, {iv[7], !iv[7]});
            if (iv[7])
                check(m1_bid == iv[3:0] && m1_bresp == iv[5:4], "R8 acc id", m1_bid, iv[3:0]);
            else
                check(m0_bid == iv && m0_bresp == iv[5:4], "R8 host id", m0_bid, iv);
            check(s_bready == (iv[7] ? iv[1] : ~iv[1]), "R9 b ready", s_bready, iv[7] ? iv[1] : ~iv[1]);
        end
        step(); idle_all();

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule